// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block turns two packed 8-bit timing registers into the time base of a CAN node. A prescaler divides the system clock into time quanta, and a sequencer walks every bit through a one-quantum sync segment, a first timing segment and a second timing segment. It raises a one-clock sample pulse at the boundary between the two timing segments and outputs the sampled bus level, taken from one sample or from a majority vote over three.

The sequencer follows the bus. The first recessive-to-dominant transition in a bit moves the bit boundary. An edge in the first segment makes that segment longer. An edge in the second segment makes that segment shorter. Both corrections are limited by the programmed jump width. While the bus is idle, any falling edge restarts the bit instead. The timing registers accept writes only while the configuration-change enable input is high, so a running node cannot have its timing changed by accident.

Top module: `can_bit_timing`

## Requirements
- R1: While `rst_n` is low, `timing0` and `timing1` read 0x00, `seg` is 0 (sync), `sample_pulse` is 0 and `sample_bit` is 1 (recessive).
- R2: A write with `wr_en` high loads `wr_data` into `timing0` when `wr_sel`=0 and into `timing1` when `wr_sel`=1. The write takes effect only when `cfg_en` is high in the same clock. Otherwise both registers keep their value.
- R3: `timing0[5:0]` holds the prescaler minus one (1 to 64). `tq_tick` pulses for one clock once every prescaler clocks, and each pulse ends one time quantum.
- R4: `timing1[3:0]` holds the first segment length minus one (1 to 16 quanta), and `timing1[6:4]` holds the second segment length minus one (1 to 8). Without edges, a bit lasts 1 + first + second quanta. `seg` reads 0 for sync, 1 for the first segment and 2 for the second.
- R5: `sample_pulse` is high for one clock, in the clock after the tick that ends the first segment. When it rises, `seg` has just changed to 2. A falling edge in the sync quantum makes no correction.
- R6: The first falling edge of a bit seen in the first segment, during its k-th quantum (counting from 1), lengthens that segment by min(k, jump width) quanta.
- R7: The first falling edge of a bit seen in the second segment, with r quanta of that segment left (including the current one), shortens that segment by the jump width if r exceeds it. Otherwise the edge quantum becomes the sync quantum of the next bit, and the first segment starts at the next quantum.
- R8: `timing0[7:6]` holds the jump width minus one (1 to 4 quanta). It limits both corrections.
- R9: With `bus_idle` high, a falling edge in any segment makes the next quantum the first quantum of the first segment. No sample is taken in the quantum where the edge was detected.
- R10: With `timing1[7]`=1, `sample_bit` is the majority of the bus levels at the sample tick and at the two ticks before it. With `timing1[7]`=0, `sample_bit` is the level at the sample tick only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration-change enable; gates register writes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 prescaler/jump width, 1 segments/mode |
| wr_data | input | 8 | Write data |
| rx_in | input | 1 | Bus receive level, 1 = recessive |
| bus_idle | input | 1 | Bus idle; falling edges cause a hard sync |
| tq_tick | output | 1 | One-clock pulse at the end of each time quantum |
| seg | output | 2 | Current segment: 0 sync, 1 first, 2 second |
| sample_pulse | output | 1 | One-clock pulse marking the sample point |
| sample_bit | output | 1 | Sampled bus level, updated with sample_pulse |
| timing0 | output | 8 | Readback of prescaler and jump width register |
| timing1 | output | 8 | Readback of segment and sampling mode register |

## Verification
A corrupted timing register shows at its readback port in the clock after the write. A wrong prescaler count or segment counter moves the next sample pulse by whole clocks or whole quanta, so the spacing between consecutive pulses reveals it within one bit time. A correction amount that is left uncleared, or clipped wrongly, shows as a bit period that differs from the nominal one in the bit containing the edge. A faulty history of bus samples shows in the first sample that depends on the earlier two levels.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_TSEG1 = 2'd1,
        SEG_TSEG2 = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_regs.sv
module cbt_regs #(
    parameter int W0 = 8,
    parameter int W1 = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [W0-1:0] wr_data,
    output logic [W0-1:0] timing0,
    output logic [W1-1:0] timing1
);
    typedef struct packed {
        logic [W0-1:0] r0;
        logic [W1-1:0] r1;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && cfg_en) begin
            if (wr_sel) st_d.r1 = W1'(wr_data);
            else        st_d.r0 = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timing0 = st_q.r0;
    assign timing1 = st_q.r1;
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_m1,
    output logic             tick
);
    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        tick = (st_q.cnt >= brp_m1);
        st_d.cnt = tick ? '0 : st_q.cnt + BRP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_in,
    input  logic             bus_idle,
    input  logic [TS1_W-1:0] tseg1_m1,
    input  logic [TS2_W-1:0] tseg2_m1,
    input  logic [SJW_W-1:0] sjw_m1,
    input  logic             triple,
    output logic [1:0]       seg_o,
    output logic             sample_o,
    output logic             bit_o
);
    localparam int QW = TS1_W + 2;

    typedef struct packed {
        seg_e          seg;
        logic [QW-1:0] qcnt;
        logic [QW-1:0] ext;
        logic [QW-1:0] shrt;
        logic          used;
        logic          rx;
        logic          prev;
        logic          sample;
        logic          bitv;
    } seq_t;

    seq_t st_d, st_q;

    logic [QW-1:0] t1_len, t2_len, sjw_len;
    logic [QW-1:0] ext_n, shrt_n, t1_end, t2_end, rem;
    logic          edge_f, vote;

    always_comb begin
        t1_len  = QW'(tseg1_m1) + QW'(1);
        t2_len  = QW'(tseg2_m1) + QW'(1);
        sjw_len = QW'(sjw_m1) + QW'(1);
        edge_f  = tick && st_q.rx && !rx_in;
        vote    = (st_q.prev & st_q.rx) | (st_q.prev & rx_in) | (st_q.rx & rx_in);
        ext_n   = st_q.ext;
        shrt_n  = st_q.shrt;
        t1_end  = t1_len - QW'(1) + ext_n;
        t2_end  = t2_len - QW'(1) - shrt_n;
        rem     = t2_len - st_q.qcnt;

        st_d        = st_q;
        st_d.sample = 1'b0;

        if (tick) begin
            st_d.rx   = rx_in;
            st_d.prev = st_q.rx;
            if (edge_f && bus_idle) begin
                // hard sync: the edge quantum becomes the new sync quantum
                st_d.seg  = SEG_TSEG1;
                st_d.qcnt = '0;
                st_d.ext  = '0;
                st_d.shrt = '0;
                st_d.used = 1'b1;
            end else begin
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg  = SEG_TSEG1;
                        st_d.qcnt = '0;
                        st_d.ext  = '0;
                        st_d.shrt = '0;
                        st_d.used = edge_f;
                    end
                    SEG_TSEG1: begin
                        if (edge_f && !st_q.used) begin
                            ext_n = (st_q.qcnt + QW'(1) < sjw_len) ? st_q.qcnt + QW'(1) : sjw_len;
                            st_d.ext  = ext_n;
                            st_d.used = 1'b1;
                        end
                        t1_end = t1_len - QW'(1) + ext_n;
                        if (st_q.qcnt >= t1_end) begin
                            st_d.seg    = SEG_TSEG2;
                            st_d.qcnt   = '0;
                            st_d.sample = 1'b1;
                            st_d.bitv   = triple ? vote : rx_in;
                        end else begin
                            st_d.qcnt = st_q.qcnt + QW'(1);
                        end
                    end
                    SEG_TSEG2: begin
                        if (edge_f && !st_q.used && rem <= sjw_len) begin
                            st_d.seg  = SEG_TSEG1;
                            st_d.qcnt = '0;
                            st_d.ext  = '0;
                            st_d.shrt = '0;
                            st_d.used = 1'b1;
                        end else begin
                            if (edge_f && !st_q.used) begin
                                shrt_n    = sjw_len;
                                st_d.shrt = shrt_n;
                                st_d.used = 1'b1;
                            end
                            t2_end = t2_len - QW'(1) - shrt_n;
                            if (st_q.qcnt >= t2_end) begin
                                st_d.seg  = SEG_SYNC;
                                st_d.qcnt = '0;
                            end else begin
                                st_d.qcnt = st_q.qcnt + QW'(1);
                            end
                        end
                    end
                    default: st_d.seg = SEG_SYNC;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.seg  <= SEG_SYNC;
            st_q.rx   <= 1'b1;
            st_q.prev <= 1'b1;
            st_q.bitv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o    = st_q.seg;
    assign sample_o = st_q.sample;
    assign bit_o    = st_q.bitv;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
    parameter int BRP_W = 6,
    parameter int SJW_W = 2,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_en,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [BRP_W+SJW_W-1:0]   wr_data,
    input  logic                     rx_in,
    input  logic                     bus_idle,
    output logic                     tq_tick,
    output logic [1:0]               seg,
    output logic                     sample_pulse,
    output logic                     sample_bit,
    output logic [BRP_W+SJW_W-1:0]   timing0,
    output logic [TS1_W+TS2_W:0]     timing1
);
    localparam int W0 = BRP_W + SJW_W;
    localparam int W1 = TS1_W + TS2_W + 1;

    cbt_regs #(.W0(W0), .W1(W1)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .timing0 (timing0),
        .timing1 (timing1)
    );

    cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .brp_m1 (timing0[BRP_W-1:0]),
        .tick   (tq_tick)
    );

    cbt_sequencer #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tq_tick),
        .rx_in    (rx_in),
        .bus_idle (bus_idle),
        .tseg1_m1 (timing1[TS1_W-1:0]),
        .tseg2_m1 (timing1[TS1_W +: TS2_W]),
        .sjw_m1   (timing0[BRP_W +: SJW_W]),
        .triple   (timing1[W1-1]),
        .seg_o    (seg),
        .sample_o (sample_pulse),
        .bit_o    (sample_bit)
    );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       tq_tick,
    input logic [1:0] seg,
    input logic       sample_pulse,
    input logic [7:0] timing0,
    input logic [7:0] timing1
);
    // R2: without the enable in the previous clock, registers hold
    a_r2_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> ($stable(timing0) && $stable(timing1)));

    // R3: a tick is a single clock unless the prescaler is one
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> (!tq_tick || timing0[5:0] == 6'd0));

    // R3: segment only advances on a quantum tick
    a_r3_seg_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tq_tick |=> $stable(seg));

    // R4: segment code is always one of the three legal values
    a_r4_seg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        seg != 2'd3);

    // R4: sync lasts exactly one quantum
    a_r4_sync_one_tq: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == 2'd0 && tq_tick) |=> seg != 2'd0);

    // R5: the sample pulse marks the move from first to second segment
    a_r5_sample_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> (seg == 2'd2 && $past(seg) == 2'd1));

    // R10: sample pulse lasts one clock
    a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |=> !sample_pulse);
endmodule

bind can_bit_timing cbt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .tq_tick      (tq_tick),
    .seg          (seg),
    .sample_pulse (sample_pulse),
    .timing0      (timing0),
    .timing1      (timing1)
);

// File: tb/can_bit_timing_tb.sv
`timescale 1ns/1ps
module can_bit_timing_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx = 1'b1, idle = 1'b0;
    logic       tick, spulse, sbit;
    logic [1:0] seg;
    logic [7:0] t0, t1;

    int vec_n = 0;
    int bad_n = 0;

    always #10 clk = ~clk;   // 50 MHz

    can_bit_timing u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rx_in(rx), .bus_idle(idle), .tq_tick(tick), .seg(seg),
        .sample_pulse(spulse), .sample_bit(sbit), .timing0(t0), .timing1(t1)
    );

    // {timing0, timing1, bit period in clocks, sync entry to sample in clocks}
    localparam logic [47:0] VECS [6] = '{
        {8'h00, 8'h00, 16'd3,   16'd2},
        {8'h01, 8'h23, 16'd16,  16'd10},
        {8'h03, 8'h17, 16'd44,  16'd36},
        {8'h00, 8'h7F, 16'd25,  16'd17},
        {8'h3F, 8'h00, 16'd192, 16'd128},
        {8'hC2, 8'h52, 16'd30,  16'd12}
    };

    task automatic chk(input string tag, input int act, input int exp);
        vec_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d, input logic en);
        @(negedge clk);
        cfg_en = en; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; cfg_en = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!spulse);
    endtask

    task automatic wait_sync_entry();
        logic [1:0] p;
        do begin p = seg; @(negedge clk); end while (!(seg == 2'd0 && p != 2'd0));
    endtask

    task automatic edge_run(input int delay, input logic id, output int total);
        int n;
        rx = 1'b1;
        wait_pulse(n);
        total = 0;
        repeat (delay) begin @(negedge clk); total++; end
        idle = id;
        rx = 1'b0;
        do begin @(negedge clk); total++; end while (!spulse);
        rx = 1'b1;
        idle = 1'b0;
    endtask

    task automatic triple_run(input int rise_at, output logic b, output int total);
        int n;
        rx = 1'b1;
        wait_pulse(n);
        rx = 1'b0;
        wait_pulse(n);
        total = 0;
        repeat (rise_at) begin @(negedge clk); total++; end
        rx = 1'b1;
        do begin @(negedge clk); total++; end while (!spulse);
        b = sbit;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        int n, off, per, tot;
        logic b;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 timing0", t0, 0);
        chk("R1 timing1", t1, 0);
        chk("R1 seg", seg, 0);
        chk("R1 sample_pulse", spulse, 0);
        chk("R1 sample_bit", sbit, 1);
        rst_n = 1'b1;

        // R2: writes land only with the enable
        wr(1'b0, 8'h15, 1'b1);
        chk("R2 timing0 write", t0, 8'h15);
        wr(1'b0, 8'h2A, 1'b0);
        chk("R2 timing0 ignored", t0, 8'h15);
        wr(1'b1, 8'h66, 1'b0);
        chk("R2 timing1 ignored", t1, 8'h00);
        wr(1'b1, 8'h31, 1'b1);
        chk("R2 timing1 write", t1, 8'h31);

        // R3 R4 R5: nominal timing over the vector table
        for (int i = 0; i < 6; i++) begin
            wr(1'b0, VECS[i][47:40], 1'b1);
            wr(1'b1, VECS[i][39:32], 1'b1);
            wait_pulse(n);
            wait_sync_entry();
            wait_pulse(off);
            wait_pulse(per);
            chk($sformatf("R3 R4 R5 vec%0d sample offset", i), off, int'(VECS[i][15:0]));
            chk($sformatf("R3 R4 vec%0d bit period", i), per, int'(VECS[i][31:16]));
        end

        // brp 1, jump width 2, first segment 8, second segment 4: 13 quanta
        wr(1'b0, 8'h40, 1'b1);
        wr(1'b1, 8'h37, 1'b1);
        edge_run(4, 1'b0, tot);
        chk("R5 edge in sync no correction", tot, 13);
        edge_run(5, 1'b0, tot);
        chk("R6 edge in first quantum of segment one", tot, 14);
        edge_run(10, 1'b0, tot);
        chk("R6 R8 lengthen clipped to jump width 2", tot, 15);
        edge_run(0, 1'b0, tot);
        chk("R7 shorten by jump width", tot, 11);
        edge_run(3, 1'b0, tot);
        chk("R7 edge in last quantum starts next bit", tot, 12);
        edge_run(1, 1'b1, tot);
        chk("R9 hard sync while idle", tot, 10);

        wr(1'b0, 8'hC0, 1'b1);   // jump width 4
        edge_run(10, 1'b0, tot);
        chk("R8 lengthen clipped to jump width 4", tot, 17);

        // R10: majority sampling
        wr(1'b0, 8'h40, 1'b1);
        wr(1'b1, 8'hB7, 1'b1);
        triple_run(12, b, tot);
        chk("R10 majority 0,0,1 value", b, 0);
        chk("R10 rising edge keeps timing", tot, 13);
        triple_run(11, b, tot);
        chk("R10 majority 0,1,1 value", b, 1);
        wr(1'b1, 8'h37, 1'b1);
        triple_run(12, b, tot);
        chk("R10 single sample value", b, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end
endmodule